// File: doc/BRIEF.md
# Reconfigurable Cyclic Prefix Remover

This block sits in the receive path of a multicarrier modem, between symbol timing recovery and the FFT. It takes a stream of received time-domain samples. An external symbol-start marker flags the first sample of every symbol. For each symbol the block drops the leading guard (cyclic prefix) samples and passes the FFT body on as one framed packet, with start and end markers.

The FFT length and the prefix length are run-time inputs. They are sampled on the symbol-start beat and held for the rest of that symbol, so every symbol can use a different configuration. The control logic holds no direction-specific state, so the same instance can frame symbols on either side of a time-division duplex link. Each forwarded sample leaves on the registered output one clock after it is accepted.

Top module: `cp_remover`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `out_valid`, `out_sop`, `out_eop` and `sym_err` are all low.
- R2: For each symbol, the first P accepted samples are discarded and produce no `out_valid`. P is the value of `cp_len` on the symbol-start beat, and may be any value from 0 to 2047.
- R3: The N accepted samples that follow the prefix appear on `out_data` in the order they arrived, each with `out_valid` high, exactly one clock after the input beat that carried it.
- R4: `size_sel` selects N as follows: code 0 gives 128, code 1 gives 256, code 2 gives 512, code 3 gives 1024, and code 4 gives 2048. Codes 5 to 7 are treated as 2048.
- R5: `out_sop` is high only with the first forwarded sample of a symbol, and `out_eop` only with its last. When P is 0, the symbol-start sample itself carries `out_sop`.
- R6: Changes on `size_sel` and `cp_len` after the symbol-start beat have no effect on the symbol in progress.
- R7: A cycle with `in_valid` low neither advances the symbol nor produces `out_valid`.
- R8: Valid samples that arrive while no symbol is open (before any start, or after a symbol's last sample) without `in_sop` are ignored.
- R9: An `in_sop` that arrives before the current symbol has finished sets `sym_err`. That sample then begins a new symbol with the newly sampled N and P. `sym_err` stays high until reset.
- R10: Symbols with different N and P can follow each other with no idle cycle between them, and each one is framed with its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_sop | input | 1 | Marks the first sample of a symbol (qualified by in_valid) |
| in_data | input | DATA_W | Input sample |
| size_sel | input | SEL_W | FFT length code, sampled on the symbol-start beat |
| cp_len | input | CP_W | Prefix length in samples, sampled on the symbol-start beat |
| out_valid | output | 1 | Forwarded sample is valid |
| out_sop | output | 1 | First sample of an FFT packet |
| out_eop | output | 1 | Last sample of an FFT packet |
| out_data | output | DATA_W | Forwarded sample |
| sym_err | output | 1 | Sticky flag for a premature symbol start |

## Verification
The hardest situations to reach are the extremes of the counter range, together with a symbol start that lands mid-symbol. These are a 2047-sample prefix in front of a 512-point body, the largest symbol, and an early start while the prefix is still being dropped. The stimulus drives long directed symbols at these limits, including an out-of-range size code. It also drives one symbol whose start is cut short after a few samples, and one that is run with random idle gaps. A behavioural model in the bench tracks the expected output on every clock, and the number of forwarded samples per symbol is checked against the selected length.

// File: rtl/cp_remover_pkg.sv
package cp_remover_pkg;
  localparam int CPR_LOG2_MIN   = 7;   // smallest FFT length is 2**7
  localparam int CPR_NUM_SIZES  = 5;   // 128 .. 2048
  localparam int CPR_LOG2_MAX   = CPR_LOG2_MIN + CPR_NUM_SIZES - 1;
  localparam int CPR_MAX_N      = 1 << CPR_LOG2_MAX;

  // Map a size code to an FFT length; out-of-range codes saturate to the max.
  function automatic int unsigned fft_len(input int unsigned code);
    int unsigned len;
    len = CPR_MAX_N;
    for (int k = 0; k < CPR_NUM_SIZES; k++) begin
      if (code == k) len = 1 << (CPR_LOG2_MIN + k);
    end
    return len;
  endfunction
endpackage

// File: rtl/cp_remover_ctrl.sv
module cp_remover_ctrl
  import cp_remover_pkg::*;
#(
  parameter int CP_W  = 11,
  parameter int SEL_W = 3,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [SEL_W-1:0] size_sel,
  input  logic [CP_W-1:0]  cp_len,
  output logic             fwd,
  output logic             first,
  output logic             last,
  output logic             err
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] n_q, n_d;
  logic [CNT_W-1:0] cp_q, cp_d;
  logic             err_q, err_d;

  logic             start, active;
  logic [CNT_W-1:0] eff_cnt, eff_n, eff_cp, end_cnt;

  always_comb begin
    start   = in_valid & in_sop;
    active  = in_valid & (start | busy_q);
    eff_cnt = start ? '0 : cnt_q;
    eff_n   = start ? CNT_W'(fft_len(int'(size_sel))) : n_q;
    eff_cp  = start ? CNT_W'(cp_len) : cp_q;
    end_cnt = eff_n + eff_cp - CNT_W'(1);

    fwd   = active & (eff_cnt >= eff_cp);
    first = active & (eff_cnt == eff_cp);
    last  = active & (eff_cnt == end_cnt);

    busy_d = busy_q;
    cnt_d  = cnt_q;
    n_d    = n_q;
    cp_d   = cp_q;
    err_d  = err_q | (start & busy_q);
    if (active) begin
      busy_d = ~last;
      cnt_d  = last ? '0 : eff_cnt + CNT_W'(1);
      n_d    = eff_n;
      cp_d   = eff_cp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      cp_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      cp_q   <= cp_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;

  // R9: error flag never clears without reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R8: a non-start sample while idle is not forwarded and opens nothing
  p_idle_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && in_valid && !in_sop) |-> (!fwd && !busy_d));
  // R3: the running count stays inside the captured symbol length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < n_q + cp_q));
  // R6: captured settings hold while a symbol is open and no new start arrives
  p_hold_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> ($stable(n_q) && $stable(cp_q)));
endmodule

// File: rtl/cp_remover_outreg.sv
module cp_remover_outreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              first,
  input  logic              last,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data
);
  logic              v_d, s_d, e_d;
  logic [DATA_W-1:0] dat_d;

  always_comb begin
    v_d   = fwd;
    s_d   = fwd & first;
    e_d   = fwd & last;
    dat_d = fwd ? in_data : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v_d;
      out_sop   <= s_d;
      out_eop   <= e_d;
      out_data  <= dat_d;
    end
  end

  // R5: packet markers only accompany a valid output beat
  p_sop_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  p_eop_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);
endmodule

// File: rtl/cp_remover.sv
module cp_remover
  import cp_remover_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CP_W   = 11,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SEL_W-1:0]  size_sel,
  input  logic [CP_W-1:0]   cp_len,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              sym_err
);
  localparam int MAX_SYM = CPR_MAX_N + (1 << CP_W) - 1;
  localparam int CNT_W   = $clog2(MAX_SYM + 1);

  logic fwd, first, last;

  cp_remover_ctrl #(.CP_W(CP_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .size_sel(size_sel), .cp_len(cp_len),
    .fwd(fwd), .first(first), .last(last), .err(sym_err)
  );

  cp_remover_outreg #(.DATA_W(DATA_W)) oreg_i (
    .clk(clk), .rst_n(rst_n), .fwd(fwd), .first(first), .last(last),
    .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data)
  );

  // R7: an idle input cycle yields no output beat one clock later
  p_gap_no_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: tb/cp_remover_tb_top.sv
module cp_remover_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_sop;
  logic [DW-1:0] in_data;
  logic [2:0]    size_sel;
  logic [10:0]   cp_len;
  logic          out_valid, out_sop, out_eop, sym_err;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int fwd_cnt = 0;
  string tag = "R1";

  // behavioural model state
  int m_busy = 0, m_cnt = 0, m_n = 0, m_cp = 0;
  bit e_valid = 0, e_sop = 0, e_eop = 0, e_err = 0;
  logic [DW-1:0] e_data = '0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  cp_remover dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .size_sel(size_sel), .cp_len(cp_len),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data), .sym_err(sym_err)
  );

  function automatic int len_of(int code);
    if (code > 4) return 2048;  // R4: codes 5..7 saturate
    return 128 << code;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated at every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_n = 0; m_cp = 0;
      e_valid <= 0; e_sop <= 0; e_eop <= 0; e_err <= 0;
    end else begin
      bit st, act;
      int c;
      st  = in_valid && in_sop;
      act = in_valid && (st || m_busy != 0);
      if (st && m_busy != 0) e_err <= 1;
      if (st) begin m_n = len_of(int'(size_sel)); m_cp = int'(cp_len); m_cnt = 0; end
      c = m_cnt;
      e_valid <= act && c >= m_cp;
      e_sop   <= act && c == m_cp;
      e_eop   <= act && c == m_n + m_cp - 1;
      if (act && c >= m_cp) e_data <= in_data;
      if (act) begin
        if (c == m_n + m_cp - 1) begin m_busy = 0; m_cnt = 0; end
        else begin m_busy = 1; m_cnt = c + 1; end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      if (out_valid) fwd_cnt++;
      chk(out_valid == e_valid, {tag, "/R2 valid"}, out_valid, e_valid);
      chk(out_sop == e_sop, {tag, "/R5 sop"}, out_sop, e_sop);
      chk(out_eop == e_eop, {tag, "/R5 eop"}, out_eop, e_eop);
      chk(sym_err == e_err, {tag, "/R9 err"}, sym_err, e_err);
      if (e_valid) chk(out_data == e_data, {tag, "/R3 data"}, out_data, e_data);
    end
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0;
    end
  endtask

  // send one symbol; gaps inserts random idle cycles; upto truncates it
  task automatic send_sym(int code, int cp, bit gaps, bit mid_change, int upto);
    int total;
    total = len_of(code) + cp;
    if (upto > 0 && upto < total) total = upto;
    for (int i = 0; i < total; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk); in_valid = 0; in_sop = 0;
      end
      @(negedge clk);
      in_valid = 1;
      in_sop   = (i == 0);
      in_data  = DW'($urandom);
      if (i == 0) begin size_sel = 3'(code); cp_len = 11'(cp); end
      else if (mid_change) begin size_sel = 3'd3; cp_len = 11'd100; end
    end
  endtask

  task automatic sym_count(int code, int cp, string req);
    fwd_cnt = 0;
    send_sym(code, cp, 0, 0, 0);
    idle(2);
    chk(fwd_cnt == len_of(code), req, fwd_cnt, len_of(code));
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_sop = 0; in_data = '0; size_sel = '0; cp_len = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && !out_sop && !out_eop && !sym_err, "R1", out_valid, 0);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    chk(!out_valid && !sym_err, "R1", out_valid, 0);

    // R8: stray samples before any start are ignored
    tag = "R8"; fwd_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); in_valid = 1; in_sop = 0; in_data = DW'(i);
    end
    idle(2);
    chk(fwd_cnt == 0, "R8", fwd_cnt, 0);

    tag = "R2"; sym_count(0, 32, "R2 N=128 CP=32");
    tag = "R5"; sym_count(4, 0, "R5 CP=0 N=2048");
    tag = "R2"; sym_count(2, 2047, "R2 CP=2047 N=512");
    tag = "R4"; sym_count(1, 7, "R4 code1");
    tag = "R4"; sym_count(3, 1, "R4 code3");
    tag = "R4"; sym_count(5, 10, "R4 code5 saturates");
    tag = "R4"; sym_count(7, 3, "R4 code7 saturates");

    // R8: samples after a finished symbol are ignored
    tag = "R8"; fwd_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1; in_sop = 0;
    end
    idle(2);
    chk(fwd_cnt == 0, "R8 post-symbol", fwd_cnt, 0);

    // R6: control changes inside a symbol
    tag = "R6"; fwd_cnt = 0;
    send_sym(0, 4, 0, 1, 0);
    idle(2);
    chk(fwd_cnt == 128, "R6", fwd_cnt, 128);

    // R7: random idle gaps
    tag = "R7"; fwd_cnt = 0;
    send_sym(1, 17, 1, 0, 0);
    idle(2);
    chk(fwd_cnt == 256, "R7", fwd_cnt, 256);

    // R10: back-to-back symbols with differing settings
    tag = "R10"; fwd_cnt = 0;
    send_sym(0, 9, 0, 0, 0);
    send_sym(1, 0, 0, 0, 0);
    send_sym(0, 200, 0, 0, 0);
    idle(2);
    chk(fwd_cnt == 512, "R10", fwd_cnt, 512);
    chk(!sym_err, "R10 no error", sym_err, 0);

    // R9: premature start during prefix, then a full symbol
    tag = "R9"; fwd_cnt = 0;
    send_sym(0, 40, 0, 0, 20);
    send_sym(0, 5, 0, 0, 0);
    idle(2);
    chk(sym_err, "R9 set", sym_err, 1);
    chk(fwd_cnt == 128, "R9 restart", fwd_cnt, 128);
    sym_count(0, 1, "R9 sticky run");
    chk(sym_err, "R9 sticky", sym_err, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule